// File: doc/BRIEF.md
# Satellite-control envelope bit transmitter

This block drives the on/off envelope that gates an external tone generator used for signalling toward a satellite dish's low-noise block. Software or a sequencer loads a message length and an end-of-message burst choice, pulses `start_i`, then supplies the message bytes over a valid/ready byte stream. The block sends each byte as pulse-width coded bits, most significant first, with a parity bit after each byte. It wraps the message in fixed low silences and can end it with a plain tone burst or a data burst. While no transfer is running, the pin follows a static tone-enable input.

All durations are given in microseconds through parameters and converted to clock cycles with `CYC_PER_US`. The default durations are 500 and 1000 us for the two halves of a bit, 16 ms for each guard silence, 12.5 ms for the plain burst and 20 ms for the closing idle gap.

Byte stream rules: `in_ready_o` is high only while a transfer is running, the one-byte holding register is empty, and message bytes are still owed. A byte moves on a cycle where `in_valid_i` and `in_ready_o` are both high. The source may hold `in_valid_i` low for any time. If the next byte has not arrived when the current byte's parity bit ends, the pin stays low until it arrives, and no byte is dropped.

Top module: `sec_envelope_tx`

## Requirements
- R1: A one bit is a high mark of SHORT_US then a low space of LONG_US. A zero bit is a mark of LONG_US then a space of SHORT_US. Each duration lasts the given number of microseconds times CYC_PER_US clock cycles.
- R2: Each byte goes out most significant bit first and is followed by a ninth bit: 1 XOR all eight data bits, so the nine bits have odd parity.
- R3: The pin is low for GUARD_US before the first byte and low for GUARD_US after the last message byte.
- R4: The burst choice `burst_i` is latched at start. 2'b01 drives the pin high for TONE_US after the trailing silence. 2'b10 sends byte 0xFF plus its parity bit (1) with normal bit coding. 2'b00 and 2'b11 send no burst.
- R5: After a burst the pin stays low for GAP_US, then one done cycle follows, also low. With no burst, the done cycle follows the trailing silence directly.
- R6: While no transfer is running, `env_o` equals `tone_on_i`. During a transfer `tone_on_i` has no effect.
- R7: `busy_o` rises in the cycle after an accepted start. `done_o` is high for exactly one cycle, the last cycle of `busy_o`.
- R8: A start request while `busy_o` is high is ignored. The running transfer is unchanged, and no new transfer follows it.
- R9: A length of zero sends only the two silences (merged into one low period) and then the selected burst, if any.
- R10: Bytes are taken under the valid/ready rules above. When the source withholds a byte, the low space before it grows until it arrives, and every other bit keeps its exact timing.
- R11: A length above MAX_LEN is treated as MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| len_i | input | LEN_W | Message byte count |
| burst_i | input | 2 | End-of-message burst choice |
| tone_on_i | input | 1 | Static tone level used while idle |
| in_valid_i | input | 1 | Message byte valid |
| in_data_i | input | 8 | Message byte |
| in_ready_o | output | 1 | Block can take a message byte |
| env_o | output | 1 | Tone envelope |
| busy_o | output | 1 | Transfer running |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest case to reach is a source that runs dry in the middle of a message. The holding register normally fills long before it is needed, so the stall path only runs if the source withholds a byte for longer than a whole byte takes to send. The bench does this by holding back the second byte of a three-byte message for several hundred cycles. It then checks that only the parity space before that byte grew, while every other run of the waveform matched exactly. A second hard case is a start that arrives mid-transfer. The bench raises start with different settings part-way through a byte and checks both the waveform and that the block stays idle afterwards.

// File: rtl/sec_env_pkg.sv
package sec_env_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LEAD, ST_FETCH, ST_MARK, ST_SPACE,
    ST_TRAIL, ST_TONE, ST_GAP, ST_DONE
  } sec_state_e;

  typedef enum logic [1:0] {
    BURST_NONE = 2'b00,
    BURST_TONE = 2'b01,
    BURST_DATA = 2'b10,
    BURST_OFF  = 2'b11
  } sec_burst_e;
endpackage

// File: rtl/sec_env_timer.sv
module sec_env_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i - TW'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - TW'(1);
  end

  assign expired_o = (cnt_q == '0);

  assert_load_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (load_val_i != '0));
endmodule

// File: rtl/sec_env_serializer.sv
module sec_env_serializer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       advance_i,
  output logic       bit_o,
  output logic       next_bit_o,
  output logic       last_o
);
  logic [7:0] sr_q;
  logic       par_q;
  logic [3:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      par_q <= 1'b1;
      idx_q <= 4'd8;
    end else if (load_i) begin
      sr_q  <= byte_i;
      par_q <= ~^byte_i;
      idx_q <= '0;
    end else if (advance_i && idx_q != 4'd8) begin
      sr_q  <= {sr_q[6:0], 1'b0};
      idx_q <= idx_q + 4'd1;
    end
  end

  assign last_o     = (idx_q == 4'd8);
  assign bit_o      = last_o ? par_q : sr_q[7];
  assign next_bit_o = (idx_q == 4'd7) ? par_q : sr_q[6];

  assert_index_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= 4'd8);
  assert_no_advance_past_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !load_i) |-> !last_o);
endmodule

// File: rtl/sec_env_feeder.sv
module sec_env_feeder #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             fin_i,
  input  logic             take_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             full_o,
  output logic [7:0]       data_o
);
  logic             active_q, full_q;
  logic [7:0]       data_q;
  logic [LEN_W-1:0] want_q, got_q;

  assign in_ready_o = active_q && !full_q && (got_q != want_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      data_q   <= '0;
      want_q   <= '0;
      got_q    <= '0;
    end else if (arm_i) begin
      active_q <= 1'b1;
      full_q   <= 1'b0;
      want_q   <= len_i;
      got_q    <= '0;
    end else if (fin_i) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
    end else if (in_valid_i && in_ready_o) begin
      full_q <= 1'b1;
      data_q <= in_data_i;
      got_q  <= got_q + LEN_W'(1);
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  assert_take_needs_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> full_q);
  assert_count_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    got_q <= want_q);
endmodule

// File: rtl/sec_envelope_tx.sv
module sec_envelope_tx
  import sec_env_pkg::*;
#(
  parameter int CYC_PER_US = 27,
  parameter int SHORT_US   = 500,
  parameter int LONG_US    = 1000,
  parameter int GUARD_US   = 16000,
  parameter int TONE_US    = 12500,
  parameter int GAP_US     = 20000,
  parameter int MAX_LEN    = 8,
  parameter int LEN_W      = $clog2(MAX_LEN + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [1:0]       burst_i,
  input  logic             tone_on_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             env_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int C_SHORT = SHORT_US * CYC_PER_US;
  localparam int C_LONG  = LONG_US  * CYC_PER_US;
  localparam int C_GUARD = GUARD_US * CYC_PER_US;
  localparam int C_TONE  = TONE_US  * CYC_PER_US;
  localparam int C_GAP   = GAP_US   * CYC_PER_US;
  localparam int C_M1    = (C_SHORT > C_LONG) ? C_SHORT : C_LONG;
  localparam int C_M2    = (C_GUARD > C_TONE) ? C_GUARD : C_TONE;
  localparam int C_M3    = (C_M1 > C_M2) ? C_M1 : C_M2;
  localparam int C_MAX   = (C_M3 > C_GAP) ? C_M3 : C_GAP;
  localparam int TW      = $clog2(C_MAX + 1);

  sec_state_e       st_q, nxt;
  sec_burst_e       burst_q;
  logic [LEN_W-1:0] len_q, started_q, len_clamped;
  logic             in_burst_q;

  logic          tload, t_exp;
  logic [TW-1:0] tval;
  logic          ser_load, ser_adv, ser_bit, ser_next, ser_last;
  logic [7:0]    ser_byte;
  logic          take, arm, fin, feed_full, set_burst;
  logic [7:0]    feed_data;
  logic          want_next, want_trail, more;

  function automatic logic [TW-1:0] mark_len(input logic b);
    return b ? TW'(C_SHORT) : TW'(C_LONG);
  endfunction

  function automatic logic [TW-1:0] space_len(input logic b);
    return b ? TW'(C_LONG) : TW'(C_SHORT);
  endfunction

  assign len_clamped = (len_i > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : len_i;
  assign more        = (started_q != len_q);

  sec_env_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tload), .load_val_i(tval), .expired_o(t_exp)
  );

  sec_env_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .load_i(ser_load), .byte_i(ser_byte),
    .advance_i(ser_adv), .bit_o(ser_bit), .next_bit_o(ser_next), .last_o(ser_last)
  );

  sec_env_feeder #(.LEN_W(LEN_W)) u_feed (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .len_i(len_clamped), .fin_i(fin),
    .take_i(take), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .in_ready_o(in_ready_o), .full_o(feed_full), .data_o(feed_data)
  );

  always_comb begin
    nxt        = st_q;
    tload      = 1'b0;
    tval       = '0;
    ser_load   = 1'b0;
    ser_byte   = feed_data;
    ser_adv    = 1'b0;
    take       = 1'b0;
    arm        = 1'b0;
    fin        = 1'b0;
    set_burst  = 1'b0;
    want_next  = 1'b0;
    want_trail = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        nxt = ST_LEAD; tload = 1'b1; tval = TW'(C_GUARD); arm = 1'b1;
      end
      ST_LEAD: if (t_exp) begin
        if (more) want_next = 1'b1;
        else      want_trail = 1'b1;
      end
      ST_FETCH: want_next = 1'b1;
      ST_MARK: if (t_exp) begin
        nxt = ST_SPACE; tload = 1'b1; tval = space_len(ser_bit);
      end
      ST_SPACE: if (t_exp) begin
        if (!ser_last) begin
          ser_adv = 1'b1; nxt = ST_MARK; tload = 1'b1; tval = mark_len(ser_next);
        end else if (in_burst_q) begin
          nxt = ST_GAP; tload = 1'b1; tval = TW'(C_GAP);
        end else if (more) want_next = 1'b1;
        else               want_trail = 1'b1;
      end
      ST_TRAIL: if (t_exp) begin
        unique case (burst_q)
          BURST_TONE: begin nxt = ST_TONE; tload = 1'b1; tval = TW'(C_TONE); end
          BURST_DATA: begin
            ser_load = 1'b1; ser_byte = 8'hFF; set_burst = 1'b1;
            nxt = ST_MARK; tload = 1'b1; tval = mark_len(1'b1);
          end
          default: nxt = ST_DONE;
        endcase
      end
      ST_TONE: if (t_exp) begin nxt = ST_GAP; tload = 1'b1; tval = TW'(C_GAP); end
      ST_GAP:  if (t_exp) nxt = ST_DONE;
      ST_DONE: begin nxt = ST_IDLE; fin = 1'b1; end
      default: nxt = ST_IDLE;
    endcase
    if (want_next) begin
      if (feed_full) begin
        take = 1'b1; ser_load = 1'b1; ser_byte = feed_data;
        nxt = ST_MARK; tload = 1'b1; tval = mark_len(feed_data[7]);
      end else begin
        nxt = ST_FETCH;
      end
    end
    if (want_trail) begin
      nxt = ST_TRAIL; tload = 1'b1; tval = TW'(C_GUARD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      burst_q    <= BURST_NONE;
      len_q      <= '0;
      started_q  <= '0;
      in_burst_q <= 1'b0;
    end else begin
      st_q <= nxt;
      if (st_q == ST_IDLE && start_i) begin
        burst_q    <= sec_burst_e'(burst_i);
        len_q      <= len_clamped;
        started_q  <= '0;
        in_burst_q <= 1'b0;
      end else begin
        if (take)      started_q  <= started_q + LEN_W'(1);
        if (set_burst) in_burst_q <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_MARK, ST_TONE: env_o = 1'b1;
      ST_IDLE:          env_o = tone_on_i;
      default:          env_o = 1'b0;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_DONE);

  assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  assert_idle_follows_tone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (env_o == tone_on_i));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(len_q) && $stable(burst_q)));
  assert_silence_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LEAD || st_q == ST_TRAIL || st_q == ST_GAP || st_q == ST_FETCH) |-> !env_o);
  assert_len_clamped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LEN_W'(MAX_LEN));
endmodule

// File: tb/sec_envelope_tx_tb.sv
module sec_envelope_tx_tb;
  localparam int CPU = 2, SUS = 3, LUS = 6, GUS = 20, TUS = 25, PUS = 40, MAXL = 4;
  localparam int S = SUS * CPU, L = LUS * CPU, G = GUS * CPU, U = TUS * CPU, P = PUS * CPU;
  localparam int LW = $clog2(MAXL + 1) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, tone_on_i = 1'b0, in_valid_i = 1'b0;
  logic [LW-1:0] len_i = '0;
  logic [1:0] burst_i = 2'b00;
  logic [7:0] in_data_i = '0;
  logic in_ready_o, env_o, busy_o, done_o;

  always #10 clk = ~clk;

  sec_envelope_tx #(.CYC_PER_US(CPU), .SHORT_US(SUS), .LONG_US(LUS), .GUARD_US(GUS),
    .TONE_US(TUS), .GAP_US(PUS), .MAX_LEN(MAXL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i), .burst_i(burst_i),
    .tone_on_i(tone_on_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .in_ready_o(in_ready_o), .env_o(env_o), .busy_o(busy_o), .done_o(done_o));

  int checks = 0, errors = 0;
  int e_lvl[0:1023], e_len[0:1023], e_n;
  int c_lvl[0:1023], c_len[0:1023], c_n;
  logic [7:0] src_mem[0:7];
  int src_idx = 0, hold_idx = -1, hold_left = 0;
  bit hs_pend = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic add(input int lv, input int n);
    if (e_n > 0 && e_lvl[e_n-1] == lv) e_len[e_n-1] += n;
    else begin e_lvl[e_n] = lv; e_len[e_n] = n; e_n++; end
  endtask

  task automatic add_byte(input logic [7:0] b);
    logic p;
    p = 1'b1;
    for (int k = 7; k >= 0; k--) begin
      add(1, b[k] ? S : L); add(0, b[k] ? L : S); p = p ^ b[k];
    end
    add(1, p ? S : L); add(0, p ? L : S);
  endtask

  task automatic cap(input logic lv);
    if (c_n > 0 && c_lvl[c_n-1] == int'(lv)) c_len[c_n-1]++;
    else begin c_lvl[c_n] = int'(lv); c_len[c_n] = 1; c_n++; end
  endtask

  // byte source: valid/ready, optional hold on one index
  always @(negedge clk) begin
    if (hs_pend) src_idx = src_idx + 1;
    if (hold_left > 0 && src_idx == hold_idx) hold_left = hold_left - 1;
    in_valid_i = (src_idx < 8) && !(src_idx == hold_idx && hold_left > 0);
    in_data_i  = src_mem[src_idx & 7];
    hs_pend    = in_valid_i && in_ready_o;
  end

  task automatic run_txn(input int len, input logic [1:0] bm, input int hold_i, input int hold_n,
                         input int poke_at, input int stall_run, input string req);
    int nb, n, dcnt, dlast, bad;
    e_n = 0; c_n = 0;
    add(0, G);
    nb = (len > MAXL) ? MAXL : len;
    for (int i = 0; i < nb; i++) add_byte(src_mem[i]);
    add(0, G);
    if (bm == 2'b01) begin add(1, U); add(0, P); end
    else if (bm == 2'b10) begin add_byte(8'hFF); add(0, P); end
    add(0, 1);
    @(negedge clk);
    src_idx = 0; hs_pend = 0; hold_idx = hold_i; hold_left = hold_n;
    len_i = LW'(len); burst_i = bm; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R7", "busy after start", int'(busy_o), 1);
    n = 0; dcnt = 0; dlast = -1;
    while (busy_o && n < 20000) begin
      cap(env_o);
      if (done_o) begin dcnt++; dlast = n; end
      if (n == poke_at) begin start_i = 1'b1; len_i = LW'(1); burst_i = 2'b01; end
      else start_i = 1'b0;
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    chk(dcnt == 1, "R7", "done pulse count", dcnt, 1);
    chk(dlast == n - 1, "R7", "done in last busy cycle", dlast, n - 1);
    chk(c_n == e_n, req, "envelope run count", c_n, e_n);
    bad = -1;
    for (int i = 0; i < c_n && i < e_n; i++) begin
      if (bad < 0) begin
        if (i == stall_run) begin
          if (!(c_lvl[i] == 0 && c_len[i] > e_len[i])) bad = i;
        end else if (c_lvl[i] != e_lvl[i] || c_len[i] != e_len[i]) bad = i;
      end
    end
    chk(bad < 0, req, $sformatf("envelope run %0d length", bad),
        (bad >= 0) ? c_len[bad] : 0, (bad >= 0) ? e_len[bad] : 0);
    repeat (3) @(negedge clk);
    chk(!busy_o && env_o == tone_on_i, "R8", "idle after transfer", int'(busy_o), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) src_mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o, "R7", "reset busy/done", int'(busy_o), 0);
    chk(!in_ready_o, "R10", "reset ready", int'(in_ready_o), 0);
    chk(env_o == 1'b0, "R6", "reset envelope", int'(env_o), 0);
    tone_on_i = 1'b1; @(negedge clk);
    chk(env_o == 1'b1, "R6", "idle tone on", int'(env_o), 1);
    tone_on_i = 1'b0; @(negedge clk);
    chk(env_o == 1'b0, "R6", "idle tone off", int'(env_o), 0);

    // R1 R2: every byte value as a one-byte message
    for (int v = 0; v < 256; v++) begin
      src_mem[0] = 8'(v);
      run_txn(1, 2'b00, -1, 0, -1, -1, "R1 R2");
    end

    // R3 R4 R5 R9: all burst choices over all lengths, tone toggled
    src_mem[0] = 8'hA5; src_mem[1] = 8'h3C; src_mem[2] = 8'h00; src_mem[3] = 8'hFF;
    src_mem[4] = 8'h81; src_mem[5] = 8'h7E;
    for (int bm = 0; bm < 4; bm++) begin
      for (int ln = 0; ln <= MAXL; ln++) begin
        tone_on_i = ln[0];
        run_txn(ln, 2'(bm), -1, 0, -1, -1, "R3 R4 R5 R9");
      end
    end
    tone_on_i = 1'b0;

    // R11: length above the limit
    run_txn(6, 2'b10, -1, 0, -1, -1, "R11");

    // R10: source withholds the second byte
    run_txn(3, 2'b00, 1, 400, -1, 18, "R10");

    // R8: start raised mid-transfer with other settings
    tone_on_i = 1'b1;
    run_txn(2, 2'b00, -1, 0, 100, -1, "R8");
    tone_on_i = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule